// File: doc/BRIEF.md
# Dual-Clock Parallel Host Port

This block links an external host processor to an internal core through a byte-wide parallel port. Two independent paths carry bytes between the host and the core, one in each direction, and both can run at the same time. Each path has two storage stages: a holding register on the sending side and a data register on the receiving side. A second byte can therefore wait while the first one is still unread. The host side runs on `hclk`, the core side runs on `cclk`, and the two clocks have no fixed phase relation. Each path crosses between the domains with a toggle request and acknowledge pair. Each toggle passes through two synchronizer flops, and the sending register stays frozen until the acknowledge returns.

The core reaches the port through a small memory-mapped register set. The core can service the port by polling a status register or by using two level interrupts, one per direction. The host sees its own bank only: a data register and a status register, addressed through the port pins.

The port has sixteen pads. A core register chooses, pin by pin, whether each pad serves the host function or acts as a general-purpose I/O bit. Each GPIO bit has its own direction bit and output value, and its input level can be read back by the core.

Top module: `dual_host_port`

## Requirements
- R1: After reset, the core status register (address 2) reads 0x02, where bit 0 means "receive register full" and bit 1 means "transmit buffer empty". After reset, the pad select registers (addresses 4 and 5) read 0, `pad_oe` is all zero, and both interrupts are low.
- R2: The host writes a byte by driving pin 11 (select), pin 9 (write) and pin 8 (address) = 0 with the data on pins 7..0. That byte appears at core address 0 and sets status bit 0. A core read of address 0 with `c_re` high removes the byte and clears the bit.
- R3: Host-to-core bytes arrive in the order written. Once one byte sits in the core register and a second byte waits in the host holding register, the host status register (pin 8 = 1) reads 0x00. In the host status register, bit 0 means "a byte is ready for the host" and bit 1 means "room for a host write".
- R4: A core write to address 1 is delivered to the host data register. The host then reads status 0x03 and can read the byte with pin 10 (read), pin 11 high and pin 8 = 0. During that read, `pad_oe[7:0]` is 0xFF, and the read frees the register.
- R5: Core-to-host bytes arrive in the order written. Once the host register is full and a second byte waits in the core transmit buffer, core status bit 1 is 0.
- R6: A host write and a core write issued in the same interval both complete, each in its own direction, with no corruption.
- R7: `rx_irq` equals the AND of enable bit 0 (address 3) and core status bit 0. It rises when a received byte lands in the core register and falls on the clock after the core reads that register.
- R8: `tx_irq` equals the AND of enable bit 1 (address 3) and core status bit 1. It drops on the clock after a core write to address 1, and it returns once the byte has moved to the host side.
- R9: A host write while its holding register is occupied is ignored. A core write to address 1 while the core transmit buffer is occupied is ignored.
- R10: For a pad whose select bit is 0, `pad_oe` follows the direction bit (addresses 6 and 7) and `pad_o` follows the output value (addresses 8 and 9).
- R11: Cores reads of addresses 10 and 11 return the levels on `pad_i[7:0]` and `pad_i[15:8]`, after a two-flop synchronizer.
- R12: A host strobe has no effect while the select bit of pin 11 is 0.
- R13: With their select bits set, pin 12 drives "a byte is ready for the host" and pin 13 drives "room for a host write", both always enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Core clock |
| hclk | input | 1 | Host-side clock, asynchronous to cclk |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| c_addr | input | 4 | Core register address |
| c_we | input | 1 | Core write enable |
| c_re | input | 1 | Core read enable (pops the receive register) |
| c_wdata | input | 8 | Core write data |
| c_rdata | output | 8 | Core read data, combinational from c_addr |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| pad_i | input | 16 | Pad input levels |
| pad_o | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |

## Verification
Register reads, GPIO outputs and the interrupt levels settle within one `cclk` edge of a core access, so the bench samples them on the falling edge that follows that access. A GPIO input needs two `cclk` edges before it can be read, so the bench waits four. A byte crossing the domains takes one source-clock edge to launch and two destination edges to synchronize plus one to capture. Its acknowledge then takes two more source-clock edges to return, which comes to about twelve `cclk` periods in all. The bench therefore waits twenty `cclk` periods after each crossing before it checks a flag or a data value. The checks that must show an immediate change, such as `tx_irq` dropping or `rx_irq` clearing, are sampled on the very next falling edge.

// File: rtl/dual_host_port.sv
module dual_host_port #(
  parameter int DW   = 8,
  parameter int NPAD = 16
) (
  input  logic            cclk,
  input  logic            hclk,
  input  logic            rst_n,
  input  logic [3:0]      c_addr,
  input  logic            c_we,
  input  logic            c_re,
  input  logic [DW-1:0]   c_wdata,
  output logic [DW-1:0]   c_rdata,
  output logic            rx_irq,
  output logic            tx_irq,
  input  logic [NPAD-1:0] pad_i,
  output logic [NPAD-1:0] pad_o,
  output logic [NPAD-1:0] pad_oe
);

  localparam int P_ADR = DW;
  localparam int P_WR  = DW + 1;
  localparam int P_RD  = DW + 2;
  localparam int P_CS  = DW + 3;
  localparam int P_AVL = DW + 4;
  localparam int P_RDY = DW + 5;
  localparam int HB    = NPAD - DW;

  // core-side configuration
  logic [1:0]      ien;
  logic [NPAD-1:0] sel, dir, gout, gin1, gin2;

  // host-side view of the select bits
  logic [NPAD-1:0] sel_h1, sel_h;
  logic            h_cs_on, h_cs, h_wr_en, h_rd_en, h_adr;

  // host -> core path
  logic [DW-1:0] h_buf, c_rx;
  logic          h_full, h_sent, h_req, ack_h1, ack_h2;
  logic          c_ack, req_c1, req_c2, c_rx_pend, c_rxfull, c_pop;

  // core -> host path
  logic [DW-1:0] c_buf, h_rx;
  logic          c_full, c_sent, c_req, tack_c1, tack_c2, c_push;
  logic          h_ack, creq_h1, creq_h2, h_tx_pend, h_rxfull, h_pop;

  logic [NPAD-1:0] host_o, host_oe;
  logic [DW-1:0]   h_stat, c_stat;

  // ---------------- host domain ----------------
  assign h_cs_on = sel_h[P_CS];
  assign h_cs    = pad_i[P_CS] & h_cs_on;
  assign h_wr_en = h_cs & pad_i[P_WR] & sel_h[P_WR];
  assign h_rd_en = h_cs & pad_i[P_RD] & sel_h[P_RD];
  assign h_adr   = pad_i[P_ADR] & sel_h[P_ADR];
  assign h_pop   = h_rd_en & ~h_adr & h_rxfull;
  assign h_tx_pend = creq_h2 ^ h_ack;
  assign h_stat  = {{(DW-2){1'b0}}, ~h_full, h_rxfull};

  always_ff @(posedge hclk or negedge rst_n) begin
    if (!rst_n) begin
      sel_h1  <= '0;
      sel_h   <= '0;
      ack_h1  <= 1'b0;
      ack_h2  <= 1'b0;
      creq_h1 <= 1'b0;
      creq_h2 <= 1'b0;
    end else begin
      sel_h1  <= sel;
      sel_h   <= sel_h1;
      ack_h1  <= c_ack;
      ack_h2  <= ack_h1;
      creq_h1 <= c_req;
      creq_h2 <= creq_h1;
    end
  end

  always_ff @(posedge hclk or negedge rst_n) begin
    if (!rst_n) begin
      h_buf  <= '0;
      h_full <= 1'b0;
      h_sent <= 1'b0;
      h_req  <= 1'b0;
    end else if (h_wr_en && !h_adr && !h_full) begin
      h_buf  <= pad_i[DW-1:0];
      h_full <= 1'b1;
    end else if (h_full && !h_sent) begin
      h_req  <= ~h_req;
      h_sent <= 1'b1;
    end else if (h_sent && (ack_h2 == h_req)) begin
      h_full <= 1'b0;
      h_sent <= 1'b0;
    end
  end

  always_ff @(posedge hclk or negedge rst_n) begin
    if (!rst_n) begin
      h_rx     <= '0;
      h_rxfull <= 1'b0;
      h_ack    <= 1'b0;
    end else if (h_pop) begin
      h_rxfull <= 1'b0;
    end else if (h_tx_pend && !h_rxfull) begin
      h_rx     <= c_buf;
      h_rxfull <= 1'b1;
      h_ack    <= ~h_ack;
    end
  end

  // ---------------- core domain ----------------
  assign c_rx_pend = req_c2 ^ c_ack;
  assign c_pop     = c_re & (c_addr == 4'd0) & c_rxfull;
  assign c_push    = c_we & (c_addr == 4'd1) & ~c_full;
  assign c_stat    = {{(DW-2){1'b0}}, ~c_full, c_rxfull};

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      req_c1  <= 1'b0;
      req_c2  <= 1'b0;
      tack_c1 <= 1'b0;
      tack_c2 <= 1'b0;
      gin1    <= '0;
      gin2    <= '0;
    end else begin
      req_c1  <= h_req;
      req_c2  <= req_c1;
      tack_c1 <= h_ack;
      tack_c2 <= tack_c1;
      gin1    <= pad_i;
      gin2    <= gin1;
    end
  end

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      c_rx     <= '0;
      c_rxfull <= 1'b0;
      c_ack    <= 1'b0;
    end else if (c_pop) begin
      c_rxfull <= 1'b0;
    end else if (c_rx_pend && !c_rxfull) begin
      c_rx     <= h_buf;
      c_rxfull <= 1'b1;
      c_ack    <= ~c_ack;
    end
  end

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      c_buf  <= '0;
      c_full <= 1'b0;
      c_sent <= 1'b0;
      c_req  <= 1'b0;
    end else if (c_push) begin
      c_buf  <= c_wdata;
      c_full <= 1'b1;
    end else if (c_full && !c_sent) begin
      c_req  <= ~c_req;
      c_sent <= 1'b1;
    end else if (c_sent && (tack_c2 == c_req)) begin
      c_full <= 1'b0;
      c_sent <= 1'b0;
    end
  end

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= '0;
      sel  <= '0;
      dir  <= '0;
      gout <= '0;
    end else if (c_we) begin
      case (c_addr)
        4'd3: ien             <= c_wdata[1:0];
        4'd4: sel[DW-1:0]     <= c_wdata;
        4'd5: sel[NPAD-1:DW]  <= c_wdata[HB-1:0];
        4'd6: dir[DW-1:0]     <= c_wdata;
        4'd7: dir[NPAD-1:DW]  <= c_wdata[HB-1:0];
        4'd8: gout[DW-1:0]    <= c_wdata;
        4'd9: gout[NPAD-1:DW] <= c_wdata[HB-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (c_addr)
      4'd0:    c_rdata = c_rx;
      4'd2:    c_rdata = c_stat;
      4'd3:    c_rdata = {{(DW-2){1'b0}}, ien};
      4'd4:    c_rdata = sel[DW-1:0];
      4'd5:    c_rdata = DW'(sel[NPAD-1:DW]);
      4'd6:    c_rdata = dir[DW-1:0];
      4'd7:    c_rdata = DW'(dir[NPAD-1:DW]);
      4'd8:    c_rdata = gout[DW-1:0];
      4'd9:    c_rdata = DW'(gout[NPAD-1:DW]);
      4'd10:   c_rdata = gin2[DW-1:0];
      4'd11:   c_rdata = DW'(gin2[NPAD-1:DW]);
      default: c_rdata = '0;
    endcase
  end

  assign rx_irq = ien[0] & c_rxfull;
  assign tx_irq = ien[1] & ~c_full;

  // ---------------- pad mux ----------------
  always_comb begin
    host_o            = '0;
    host_oe           = '0;
    host_o[DW-1:0]    = h_adr ? h_stat : h_rx;
    host_oe[DW-1:0]   = {DW{h_rd_en}};
    host_o[P_AVL]     = h_rxfull;
    host_o[P_RDY]     = ~h_full;
    host_oe[P_AVL]    = 1'b1;
    host_oe[P_RDY]    = 1'b1;
  end

  assign pad_o  = (sel & host_o)  | (~sel & gout);
  assign pad_oe = (sel & host_oe) | (~sel & dir);

endmodule

module dual_host_port_chk #(
  parameter int DW = 8
) (
  input logic          cclk,
  input logic          hclk,
  input logic          rst_n,
  input logic          c_we,
  input logic [3:0]    c_addr,
  input logic          c_pop,
  input logic          c_rxfull,
  input logic          c_rx_pend,
  input logic          c_full,
  input logic          c_sent,
  input logic [DW-1:0] c_buf,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          h_full,
  input logic          h_sent,
  input logic [DW-1:0] h_buf,
  input logic          h_cs_on
);

  assert_rx_capture_R2: assert property (@(posedge cclk) disable iff (!rst_n)
    $rose(c_rxfull) |-> $past(c_rx_pend));

  assert_h2c_hold_R3: assert property (@(posedge hclk) disable iff (!rst_n)
    (h_sent && $past(h_sent)) |-> $stable(h_buf));

  assert_c2h_hold_R5: assert property (@(posedge cclk) disable iff (!rst_n)
    (c_sent && $past(c_sent)) |-> $stable(c_buf));

  assert_rx_irq_clear_R7: assert property (@(posedge cclk) disable iff (!rst_n)
    c_pop |=> !rx_irq);

  assert_tx_irq_drop_R8: assert property (@(posedge cclk) disable iff (!rst_n)
    (c_we && c_addr == 4'd1 && !c_full) |=> !tx_irq);

  assert_unsel_idle_R12: assert property (@(posedge hclk) disable iff (!rst_n)
    (!h_cs_on && !h_full) |=> !h_full);

endmodule

bind dual_host_port dual_host_port_chk #(.DW(DW)) u_chk (
  .cclk(cclk), .hclk(hclk), .rst_n(rst_n), .c_we(c_we), .c_addr(c_addr),
  .c_pop(c_pop), .c_rxfull(c_rxfull), .c_rx_pend(c_rx_pend),
  .c_full(c_full), .c_sent(c_sent), .c_buf(c_buf),
  .rx_irq(rx_irq), .tx_irq(tx_irq),
  .h_full(h_full), .h_sent(h_sent), .h_buf(h_buf), .h_cs_on(h_cs_on)
);

// File: tb/dual_host_port_test.sv
`timescale 1ns/1ps
module dual_host_port_test;
  logic        cclk = 0, hclk = 0, rst_n = 0;
  logic [3:0]  c_addr = '0;
  logic        c_we = 0, c_re = 0;
  logic [7:0]  c_wdata = '0, c_rdata;
  logic        rx_irq, tx_irq;
  logic [15:0] pad_i = '0, pad_o, pad_oe;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] d;

  always #10 cclk = ~cclk;
  always #17 hclk = ~hclk;

  dual_host_port uut (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge cclk);
  endtask

  task automatic core_wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge cclk); c_addr = a; c_wdata = v; c_we = 1;
    @(negedge cclk); c_we = 0;
  endtask

  task automatic core_peek(input logic [3:0] a, output logic [7:0] v);
    @(negedge cclk); c_addr = a; #1 v = c_rdata;
  endtask

  task automatic core_rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge cclk); c_addr = a; c_re = 1; #1 v = c_rdata;
    @(negedge cclk); c_re = 0;
  endtask

  task automatic host_wr(input logic adr, input logic [7:0] v);
    @(negedge hclk); pad_i[7:0] = v; pad_i[8] = adr; pad_i[9] = 1; pad_i[11] = 1;
    @(negedge hclk); pad_i[9] = 0; pad_i[11] = 0;
  endtask

  task automatic host_rd(input logic adr, output logic [7:0] v, output logic [7:0] oe);
    @(negedge hclk); pad_i[8] = adr; pad_i[10] = 1; pad_i[11] = 1;
    #1 v = pad_o[7:0]; oe = pad_oe[7:0];
    @(negedge hclk); pad_i[10] = 0; pad_i[11] = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    core_peek(4'd2, v); chk("R1 status", v, 8'h02);
    core_peek(4'd4, v); chk("R1 sel lo", v, 8'h00);
    core_peek(4'd5, v); chk("R1 sel hi", v, 8'h00);
    chk("R1 pad_oe", pad_oe, 16'h0000);
    chk("R1 irqs", {rx_irq, tx_irq}, 2'b00);
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    core_wr(4'd6, 8'hA5); core_wr(4'd8, 8'h3C);
    @(negedge cclk);
    chk("R10 oe", pad_oe[7:0], 8'hA5);
    chk("R10 out", pad_o[7:0], 8'h3C);
    pad_i = 16'h965A;
    settle(4);
    core_peek(4'd10, v); chk("R11 in lo", v, 8'h5A);
    core_peek(4'd11, v); chk("R11 in hi", v, 8'h96);
    pad_i = '0;
    core_wr(4'd6, 8'h00);
  endtask

  task automatic t_unsel;
    logic [7:0] v;
    host_wr(1'b0, 8'h77);
    settle(20);
    core_peek(4'd2, v); chk("R12 no host write", v, 8'h02);
  endtask

  task automatic t_h2c;
    logic [7:0] v;
    core_wr(4'd3, 8'h01);
    host_wr(1'b0, 8'hC3);
    settle(20);
    chk("R7 rx_irq set", rx_irq, 1'b1);
    core_peek(4'd2, v); chk("R2 status full", v, 8'h03);
    core_rd(4'd0, v); chk("R2 data", v, 8'hC3);
    chk("R7 rx_irq cleared", rx_irq, 1'b0);
    core_peek(4'd2, v); chk("R2 status popped", v, 8'h02);
  endtask

  task automatic t_h2c_dbl;
    logic [7:0] v, oe;
    host_wr(1'b0, 8'hA1); settle(20);
    host_wr(1'b0, 8'hB2); settle(20);
    host_rd(1'b1, v, oe); chk("R3 host status full", v, 8'h00);
    chk("R13 ready pin low", pad_o[13], 1'b0);
    host_wr(1'b0, 8'hEE);
    core_rd(4'd0, v); chk("R3 first byte", v, 8'hA1);
    settle(20);
    core_rd(4'd0, v); chk("R3 second byte", v, 8'hB2);
    settle(20);
    core_peek(4'd2, v); chk("R9 host overflow dropped", v, 8'h02);
    host_rd(1'b1, v, oe); chk("R3 host status room", v, 8'h02);
  endtask

  task automatic t_c2h;
    logic [7:0] v, oe;
    core_wr(4'd3, 8'h02);
    chk("R8 tx_irq idle", tx_irq, 1'b1);
    core_wr(4'd1, 8'h5E);
    chk("R8 tx_irq drop", tx_irq, 1'b0);
    settle(20);
    chk("R8 tx_irq back", tx_irq, 1'b1);
    chk("R13 avail pin", pad_o[12], 1'b1);
    host_rd(1'b1, v, oe); chk("R4 host status", v, 8'h03);
    host_rd(1'b0, v, oe); chk("R4 host data", v, 8'h5E);
    chk("R4 data drive", oe, 8'hFF);
    host_rd(1'b1, v, oe); chk("R4 host status after", v, 8'h02);
  endtask

  task automatic t_c2h_dbl;
    logic [7:0] v, oe;
    core_wr(4'd1, 8'h11); settle(20);
    core_wr(4'd1, 8'h22); settle(20);
    core_peek(4'd2, v); chk("R5 tx busy", v, 8'h00);
    core_wr(4'd1, 8'h33);
    host_rd(1'b0, v, oe); chk("R5 first byte", v, 8'h11);
    settle(20);
    host_rd(1'b0, v, oe); chk("R5 second byte", v, 8'h22);
    settle(20);
    host_rd(1'b1, v, oe); chk("R9 core overflow dropped", v, 8'h02);
    core_peek(4'd2, v); chk("R5 tx drained", v, 8'h02);
  endtask

  task automatic t_duplex;
    logic [7:0] v, oe;
    fork
      host_wr(1'b0, 8'h44);
      core_wr(4'd1, 8'h55);
    join
    settle(20);
    core_rd(4'd0, v); chk("R6 host to core", v, 8'h44);
    host_rd(1'b0, v, oe); chk("R6 core to host", v, 8'h55);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got %h exp %h", 1'b0, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #95 rst_n = 1;
    settle(2);
    t_reset;
    t_gpio;
    t_unsel;
    core_wr(4'd4, 8'hFF);
    core_wr(4'd5, 8'h3F);
    settle(20);
    t_h2c;
    t_h2c_dbl;
    t_c2h;
    t_c2h_dbl;
    t_duplex;
    d = 8'h00;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule